// File: doc/BRIEF.md
# Ready-Paced Serial Debug Port

The block connects an external debug tool to a processor core over a three-wire serial link (serial clock, data in, data out). The tool sends 34-bit frames: a start bit, a mode bit and a 32-bit word. A mode bit of 0 means an instruction for the core. A mode bit of 1 means a control word, such as trap enables, that the port keeps for the core. While a frame shifts in, the port shifts out a 2-bit status and a 32-bit data word that together describe the outcome of the transfer before it.

The serial clock and data are brought into the system clock domain through a two-stage synchroniser, and the edges are detected after it. When no frame is in flight, the data-out line carries a ready flag. The tool should wait for ready before starting a frame; if it does, each result appears in the very next frame. A frame that carries an error report has its own input thrown away. A frame that ends while an instruction is still pending makes the port abort that access with a bus error.

Top module: `dbg_serial_port`

## Requirements
- R1: After reset, the data-out line is high (ready), no instruction is offered, the control word is zero and the pending status is null.
- R2: While idle, a rising serial clock edge with data-in 1 starts a frame, and a rising edge with data-in 0 has no effect. The port then samples the mode bit and 32 payload bits MSB first on the next 33 rising edges. After each rising edge of a frame (the start edge included), data-out shows the next bit of {status[1:0], data[31:0]}, MSB first. The frame ends on the falling edge that follows the 34th rising edge.
- R3: The status code is 00 for valid data, 01 for a sequence error, 10 for a CPU exception and 11 for null. Starting a frame consumes the pending status and data: the pending status becomes null and the pending data becomes zero, so a null report carries zero data.
- R4: A completed frame with mode 0 raises instr_valid_o with the word on instr_o and holds both until cpu_done_i. A completed frame with mode 1 loads ctrl_word_o. Nothing else changes ctrl_word_o.
- R5: While idle, data-out is 1 only when no instruction is pending. A frame started while an instruction is pending keeps ready low until that frame completes and its own instruction is acknowledged.
- R6: A cpu_done_i with cpu_wr_i, given while no frame is shifting, sets the status to valid and captures cpu_wdata_i. The same write given while a frame is shifting is silently lost, and the next report is null.
- R7: A cpu_done_i with cpu_exc_i sets the pending status to CPU exception.
- R8: A frame whose outgoing status is a sequence error or an exception is ignored on completion: no instruction is offered and ctrl_word_o keeps its value.
- R9: A frame that completes (and is not ignored) while an instruction is still unacknowledged raises cpu_berr_o for exactly one cycle and withdraws the instruction. The new word is discarded and the status becomes sequence error.
- R10: An exception or data write that occurs after a frame has started is not reported by that frame. When that frame started early, the exception therefore appears two transfers after the instruction that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial clock from the debug tool |
| ser_din_i | input | 1 | Serial data from the tool |
| ser_dout_o | output | 1 | Serial data to the tool; the ready flag while idle |
| instr_valid_o | output | 1 | An instruction is offered to the core |
| instr_o | output | 32 | Offered instruction word |
| cpu_done_i | input | 1 | Core finished the offered instruction (one-cycle pulse) |
| cpu_exc_i | input | 1 | The instruction raised an exception (qualifies cpu_done_i) |
| cpu_wr_i | input | 1 | The instruction wrote the port data register (qualifies cpu_done_i) |
| cpu_wdata_i | input | 32 | Data written by the core |
| cpu_berr_o | output | 1 | Bus-error termination of the pending access |
| ctrl_word_o | output | 32 | Last accepted control word |

## Verification
The bench targets the one-transfer delay of reports, since a port that reported the current frame's outcome, or forgot to clear to null, would put the wrong status and data in the next frame. It starts frames early while an instruction is pending, checking that an exception during the shift surfaces two transfers late and that a write during the shift is lost and reported as null; a port that latched the write or reported the exception at once would fail. Error-report frames that carry instructions check that such a frame is discarded, and an unacknowledged instruction followed by a frame checks for the single bus-error pulse. Idle clock edges with data-in low check that no frame starts by mistake.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;
  typedef enum logic [1:0] {
    ST_VALID  = 2'b00,
    ST_SEQERR = 2'b01,
    ST_EXC    = 2'b10,
    ST_NULL   = 2'b11
  } dbg_status_e;
endpackage

// File: rtl/dbgp_sync.sv
module dbgp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic sdin_i,
  output logic rise_o,
  output logic fall_o,
  output logic sdin_o
);
  logic [STAGES-1:0] ck_q, dt_q;
  logic ck_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_q   <= '0;
      dt_q   <= '0;
      ck_d_q <= 1'b0;
    end else begin
      ck_q   <= {ck_q[STAGES-2:0], sclk_i};
      dt_q   <= {dt_q[STAGES-2:0], sdin_i};
      ck_d_q <= ck_q[STAGES-1];
    end
  end

  assign rise_o = ck_q[STAGES-1] & ~ck_d_q;
  assign fall_o = ~ck_q[STAGES-1] & ck_d_q;
  assign sdin_o = dt_q[STAGES-1];
endmodule

// File: rtl/dbgp_frame.sv
module dbgp_frame #(
  parameter  int DW = 32,
  localparam int FW = DW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          din_i,
  input  logic          ready_i,
  input  logic [FW-1:0] tx_word_i,
  output logic          start_o,
  output logic          done_o,
  output logic          busy_o,
  output logic          dout_o,
  output logic          rx_mode_o,
  output logic [DW-1:0] rx_data_o
);
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] LAST = CW'(FW);

  logic          act_q;
  logic [CW-1:0] cnt_q;
  logic [FW-1:0] tx_q;
  logic [DW:0]   rx_q;

  assign start_o = rise_i & ~act_q & din_i;
  assign done_o  = fall_i & act_q & (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else if (start_o) begin
      act_q <= 1'b1;
      cnt_q <= CW'(1);
      tx_q  <= tx_word_i;
    end else if (act_q && rise_i && cnt_q != LAST) begin
      tx_q  <= {tx_q[FW-2:0], 1'b0};
      rx_q  <= {rx_q[DW-1:0], din_i};
      cnt_q <= cnt_q + CW'(1);
    end else if (done_o) begin
      act_q <= 1'b0;
    end
  end

  assign busy_o    = act_q;
  assign dout_o    = act_q ? tx_q[FW-1] : ready_i;
  assign rx_mode_o = rx_q[DW];
  assign rx_data_o = rx_q[DW-1:0];
endmodule

// File: rtl/dbgp_ctrl.sv
module dbgp_ctrl
  import dbgp_pkg::*;
#(
  parameter  int DW = 32,
  localparam int FW = DW + 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          done_i,
  input  logic          busy_i,
  input  logic          rx_mode_i,
  input  logic [DW-1:0] rx_data_i,
  input  logic          cpu_done_i,
  input  logic          cpu_exc_i,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic [FW-1:0] tx_word_o,
  output logic          ready_o,
  output logic          instr_valid_o,
  output logic [DW-1:0] instr_o,
  output logic [DW-1:0] ctrl_word_o,
  output logic          cpu_berr_o
);
  dbg_status_e   st_q;
  logic [DW-1:0] data_q, instr_q, ctrl_q;
  logic          pend_q, rpt_q, berr_q;
  logic          ack;

  assign ack = cpu_done_i & pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_NULL;
      data_q  <= '0;
      instr_q <= '0;
      ctrl_q  <= '0;
      pend_q  <= 1'b0;
      rpt_q   <= 1'b0;
      berr_q  <= 1'b0;
    end else begin
      berr_q <= 1'b0;
      if (start_i) begin
        rpt_q  <= (st_q == ST_SEQERR) || (st_q == ST_EXC);
        st_q   <= ST_NULL;
        data_q <= '0;
      end
      if (ack) begin
        pend_q <= 1'b0;
        if (cpu_exc_i) st_q <= ST_EXC;
        else if (cpu_wr_i && !busy_i && !start_i) begin
          st_q   <= ST_VALID;
          data_q <= cpu_wdata_i;
        end
      end
      if (done_i && !rpt_q) begin
        if (pend_q && !ack) begin  // frame overran an unfinished access
          berr_q <= 1'b1;
          pend_q <= 1'b0;
          st_q   <= ST_SEQERR;
        end else if (!rx_mode_i) begin
          pend_q  <= 1'b1;
          instr_q <= rx_data_i;
        end else begin
          ctrl_q <= rx_data_i;
        end
      end
    end
  end

  assign tx_word_o     = {st_q, data_q};
  assign ready_o       = ~busy_i & ~pend_q;
  assign instr_valid_o = pend_q;
  assign instr_o       = instr_q;
  assign ctrl_word_o   = ctrl_q;
  assign cpu_berr_o    = berr_q;
endmodule

// File: rtl/dbg_serial_port.sv
module dbg_serial_port #(
  parameter int DW          = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ser_clk_i,
  input  logic          ser_din_i,
  output logic          ser_dout_o,
  output logic          instr_valid_o,
  output logic [DW-1:0] instr_o,
  input  logic          cpu_done_i,
  input  logic          cpu_exc_i,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_wdata_i,
  output logic          cpu_berr_o,
  output logic [DW-1:0] ctrl_word_o
);
  localparam int FW = DW + 2;

  logic          rise, fall, din_s;
  logic          start, done, busy, ready, rx_mode;
  logic [DW-1:0] rx_data;
  logic [FW-1:0] tx_word;

  dbgp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i(ser_clk_i), .sdin_i(ser_din_i),
    .rise_o(rise), .fall_o(fall), .sdin_o(din_s)
  );

  dbgp_frame #(.DW(DW)) u_frame (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall), .din_i(din_s),
    .ready_i(ready), .tx_word_i(tx_word), .start_o(start), .done_o(done),
    .busy_o(busy), .dout_o(ser_dout_o), .rx_mode_o(rx_mode), .rx_data_o(rx_data)
  );

  dbgp_ctrl #(.DW(DW)) u_ctrl (
    .clk_i, .rst_ni, .start_i(start), .done_i(done), .busy_i(busy),
    .rx_mode_i(rx_mode), .rx_data_i(rx_data), .cpu_done_i, .cpu_exc_i,
    .cpu_wr_i, .cpu_wdata_i, .tx_word_o(tx_word), .ready_o(ready),
    .instr_valid_o, .instr_o, .ctrl_word_o, .cpu_berr_o
  );
endmodule

// File: rtl/dbg_serial_port_chk.sv
module dbg_serial_port_chk #(
  parameter int DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ser_dout_o,
  input logic          instr_valid_o,
  input logic [DW-1:0] instr_o,
  input logic          cpu_done_i,
  input logic          cpu_berr_o,
  input logic [DW-1:0] ctrl_word_o,
  input logic          busy,
  input logic          done
);
  a_r9_berr_withdraws: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_berr_o |-> !instr_valid_o);
  a_r9_berr_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_berr_o |=> !cpu_berr_o);
  a_r5_not_ready_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && !busy) |-> !ser_dout_o);
  a_r4_instr_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_valid_o && !cpu_done_i && !done) |=> (instr_valid_o && $stable(instr_o)));
  a_r4_ctrl_only_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done |=> $stable(ctrl_word_o));
endmodule

bind dbg_serial_port dbg_serial_port_chk #(.DW(DW)) u_chk (
  .clk_i, .rst_ni, .ser_dout_o, .instr_valid_o, .instr_o, .cpu_done_i,
  .cpu_berr_o, .ctrl_word_o, .busy(busy), .done(done)
);

// File: tb/dbg_serial_port_tb_top.sv
module dbg_serial_port_tb_top;
  localparam int HALF = 6;
  localparam logic [1:0] S_VAL = 2'b00, S_SEQ = 2'b01, S_EXC = 2'b10, S_NUL = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b0, ser_dout;
  logic instr_valid, cpu_done = 1'b0, cpu_exc = 1'b0, cpu_wr = 1'b0, cpu_berr;
  logic [31:0] instr, cpu_wdata = '0, ctrl_word;
  int n_chk = 0, n_fail = 0, berr_cnt = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  dbg_serial_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_clk_i(ser_clk), .ser_din_i(ser_din),
    .ser_dout_o(ser_dout), .instr_valid_o(instr_valid), .instr_o(instr),
    .cpu_done_i(cpu_done), .cpu_exc_i(cpu_exc), .cpu_wr_i(cpu_wr),
    .cpu_wdata_i(cpu_wdata), .cpu_berr_o(cpu_berr), .ctrl_word_o(ctrl_word)
  );

  always @(negedge clk) if (cpu_berr) berr_cnt++;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_pulse(input bit exc, input bit wr, input logic [31:0] d);
    @(negedge clk);
    cpu_done = 1'b1; cpu_exc = exc; cpu_wr = wr; cpu_wdata = d;
    @(negedge clk);
    cpu_done = 1'b0; cpu_exc = 1'b0; cpu_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  // evt: 0 none, 1 exception, 2 write; fired while the frame is shifting
  task automatic xfer(input bit mode, input logic [31:0] w, input int evt,
                      input logic [31:0] ed, output logic [1:0] st, output logic [31:0] d);
    logic [33:0] tx, rx;
    tx = {1'b1, mode, w};
    rx = '0;
    for (int i = 0; i < 34; i++) begin
      ser_din = tx[33-i];
      repeat (HALF) @(negedge clk);
      ser_clk = 1'b1;
      repeat (HALF) @(negedge clk);
      rx[33-i] = ser_dout;
      ser_clk = 1'b0;
      if (i == 10 && evt == 1) cpu_pulse(1'b1, 1'b0, '0);
      if (i == 10 && evt == 2) cpu_pulse(1'b0, 1'b1, ed);
    end
    ser_din = 1'b0;
    repeat (HALF) @(negedge clk);
    st = rx[33:32];
    d  = rx[31:0];
  endtask

  function automatic logic [63:0] rpt(input logic [1:0] s, input logic [31:0] d);
    return {30'd0, s, d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [1:0] st;
    logic [31:0] d, ctrl_exp;
    logic [1:0] e_st;
    logic [31:0] e_d;
    int b0;
    void'($urandom(32'h5eed_1234));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 dout", ser_dout, 1);
    check("R1 valid", instr_valid, 0);
    check("R1 ctrl", ctrl_word, 0);

    // R2 idle edges with din low start nothing
    for (int i = 0; i < 3; i++) begin
      repeat (HALF) @(negedge clk); ser_clk = 1'b1;
      repeat (HALF) @(negedge clk); ser_clk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    check("R2 idle edge dout", ser_dout, 1);
    check("R2 idle edge valid", instr_valid, 0);

    // R1/R3 first frame reports null; R4 instruction dispatch
    xfer(1'b0, 32'hA5A5_0001, 0, '0, st, d);
    check("R1 R3 first report null", rpt(st, d), rpt(S_NUL, 0));
    check("R4 instr valid", instr_valid, 1);
    check("R4 instr word", instr, 32'hA5A5_0001);
    check("R5 not ready pending", ser_dout, 0);

    // R6 write while idle -> valid + data
    cpu_pulse(1'b0, 1'b1, 32'hDEAD_BEEF);
    check("R5 ready after ack", ser_dout, 1);
    xfer(1'b1, 32'h0000_00F3, 0, '0, st, d);
    check("R6 valid report", rpt(st, d), rpt(S_VAL, 32'hDEAD_BEEF));
    check("R4 ctrl word", ctrl_word, 32'h0000_00F3);
    check("R4 ctrl no instr", instr_valid, 0);
    xfer(1'b1, 32'h0000_0011, 0, '0, st, d);
    check("R3 null after consume", rpt(st, d), rpt(S_NUL, 0));

    // R7 exception, R8 report frame discarded
    xfer(1'b0, 32'h1111_2222, 0, '0, st, d);
    cpu_pulse(1'b1, 1'b0, '0);
    xfer(1'b0, 32'h3333_4444, 0, '0, st, d);
    check("R7 exc report", rpt(st, d), rpt(S_EXC, 0));
    check("R8 discarded no instr", instr_valid, 0);
    check("R8 ready after discard", ser_dout, 1);
    xfer(1'b1, 32'h7777_0000, 0, '0, st, d);
    check("R8 null after report", rpt(st, d), rpt(S_NUL, 0));
    check("R8 ctrl accepted after", ctrl_word, 32'h7777_0000);

    // R9 sequence error
    xfer(1'b0, 32'h5555_0000, 0, '0, st, d);
    b0 = berr_cnt;
    xfer(1'b0, 32'h6666_0000, 0, '0, st, d);
    check("R9 berr pulse", berr_cnt - b0, 1);
    check("R9 instr withdrawn", instr_valid, 0);
    xfer(1'b1, 32'h0BAD_0BAD, 0, '0, st, d);
    check("R9 seq report", rpt(st, d), rpt(S_SEQ, 0));
    check("R8 ctrl unchanged", ctrl_word, 32'h7777_0000);
    xfer(1'b1, 32'h0000_0001, 0, '0, st, d);
    check("R9 null after", rpt(st, d), rpt(S_NUL, 0));

    // R10 early start, exception during shift reported two transfers later
    xfer(1'b0, 32'h8888_0000, 0, '0, st, d);
    xfer(1'b0, 32'h9999_0000, 1, '0, st, d);
    check("R10 early frame null", rpt(st, d), rpt(S_NUL, 0));
    check("R5 early frame dispatched", instr, 32'h9999_0000);
    check("R5 still not ready", ser_dout, 0);
    cpu_pulse(1'b0, 1'b0, '0);
    xfer(1'b1, 32'h0000_0002, 0, '0, st, d);
    check("R10 exc two later", rpt(st, d), rpt(S_EXC, 0));
    xfer(1'b1, 32'h0000_0003, 0, '0, st, d);
    check("R10 null after", rpt(st, d), rpt(S_NUL, 0));

    // R6 write during shift is lost
    xfer(1'b0, 32'hAAAA_0000, 0, '0, st, d);
    xfer(1'b0, 32'hBBBB_0000, 2, 32'hCAFE_F00D, st, d);
    check("R6 early frame null", rpt(st, d), rpt(S_NUL, 0));
    cpu_pulse(1'b0, 1'b0, '0);
    xfer(1'b1, 32'h0000_0004, 0, '0, st, d);
    check("R6 lost write null", rpt(st, d), rpt(S_NUL, 0));
    check("R6 lost no berr", berr_cnt - b0, 1);

    // random ready-paced traffic
    e_st = S_NUL; e_d = '0; ctrl_exp = ctrl_word;
    for (int k = 0; k < 30; k++) begin
      bit mode, disc;
      int kind;
      logic [31:0] w, wd;
      mode = ($urandom % 3) == 0;
      w = $urandom; wd = $urandom; kind = $urandom % 4;
      disc = (e_st == S_EXC) || (e_st == S_SEQ);
      check("R5 ready before frame", ser_dout, 1);
      xfer(mode, w, 0, '0, st, d);
      check("R3 random report", rpt(st, d), rpt(e_st, e_d));
      e_st = S_NUL; e_d = '0;
      if (disc) begin
        check("R8 random discard", instr_valid, 0);
        check("R8 random ctrl", ctrl_word, ctrl_exp);
      end else if (mode) begin
        ctrl_exp = w;
        check("R4 random ctrl", ctrl_word, w);
      end else begin
        check("R4 random instr", {31'd0, instr_valid, instr}, {32'd1, w});
        if (kind == 0) begin cpu_pulse(1'b1, 1'b0, '0); e_st = S_EXC; end
        else if (kind == 1) cpu_pulse(1'b0, 1'b0, '0);
        else begin cpu_pulse(1'b0, 1'b1, wd); e_st = S_VAL; e_d = wd; end
      end
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule